// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block holds the software-visible registers of one descriptor-driven DMA channel. A processor reaches it through a simple 32-bit register port: a write strobe with a byte offset inside a 256-byte window, and a read data bus that always shows the register selected by that offset. The block keeps the channel's control/status word, the address of the control block to fetch next, and a free scratch debug word. It also keeps read-only copies of the descriptor fields that the engine is working on.

The control/status word is not a plain register. It has three kinds of bit. A group of bits simply store what software writes. END and INT are status flags that software clears by writing 1. The top bit requests a channel reset, and it clears itself. A small two-state channel machine, `CH_IDLE` and `CH_RUN`, holds the ACTIVE bit. Its transitions are named `go` (`CH_IDLE` to `CH_RUN`, on a control/status write that sets ACTIVE while no completion is reported), `halt` (`CH_RUN` to `CH_IDLE`, on a write that clears ACTIVE) and `finish` (`CH_RUN` to `CH_IDLE`, on engine completion). Every `go` sends a one-cycle start pulse to the engine. The engine datapath is outside this block. It reports back through completion, error, held and descriptor-load inputs.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset, every defined register reads 0, and `irq_o`, `start_o` and `cb_addr_o` are 0.
- R2: A write to offset 0x00 loads bit 0 (ACTIVE) and bits 16–23, 28 and 29 (mask 0x30FF0001) from the written value. Bits 3, 6, 7, 9–15 and 24–27 always read 0. Bits 30 (abort) and 31 (reset) always read 0. Writing abort has no effect on ACTIVE and no effect on `start_o`.
- R3: `start_o` is high for exactly the one cycle after a write to offset 0x00 that takes ACTIVE (bit 0) from 0 to 1. A write that leaves ACTIVE at 1 gives no pulse.
- R4: Writing 1 to bit 1 (END) or to bit 2 (INT) of offset 0x00 clears that flag. Writing 0 to either bit leaves the flag unchanged.
- R5: `irq_o` follows the INT flag. It drops in the cycle after INT is cleared.
- R6: Writing 1 to bit 31 of offset 0x00 clears END, INT, paused (bit 4), error (bit 8), the stored field and the control-block address. The masked bits then take the written value. The debug word and the descriptor copies are kept.
- R7: An `eng_done` pulse sets END and paused, and clears ACTIVE. It also sets INT when `eng_int_req` is high, and loads the control-block address from `eng_next_addr`.
- R8: When a control/status write and `eng_done` fall in the same cycle, the write's clear of END or INT wins. ACTIVE still ends at 0, and no start pulse is given.
- R9: Offset 0x04 (control-block address, shown on `cb_addr_o`) and offset 0x20 (debug) are read/write. A bus write to 0x04 wins over a same-cycle completion load. Writes to offsets 0x08–0x1C are ignored.
- R10: A `eng_desc_vld` pulse captures the six descriptor fields. They are read back in this order: info 0x08, source 0x0C, destination 0x10, length 0x14, stride 0x18, next block 0x1C.
- R11: Offsets above 0x20, and offsets with bits 1:0 not zero, read 0, and writes to them change nothing.
- R12: Bit 5 (held) shows `eng_held` as it is now. Bit 8 (error) is set by an `eng_err` pulse and is cleared only by the reset bit.
- R13: The paused bit is cleared when a start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset inside the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| eng_done | input | 1 | Engine finished the current descriptor |
| eng_int_req | input | 1 | Finished descriptor asks for an interrupt |
| eng_err | input | 1 | Engine error pulse |
| eng_held | input | 1 | Engine held by flow control (level) |
| eng_next_addr | input | 32 | Next control-block address, loaded on completion |
| eng_desc_vld | input | 1 | Descriptor fields valid, capture strobe |
| eng_desc_info | input | 32 | Descriptor info word |
| eng_desc_src | input | 32 | Descriptor source address |
| eng_desc_dst | input | 32 | Descriptor destination address |
| eng_desc_len | input | 32 | Descriptor length |
| eng_desc_stride | input | 32 | Descriptor stride |
| eng_desc_next | input | 32 | Descriptor next-block address |
| start_o | output | 1 | One-cycle start request to the engine |
| irq_o | output | 1 | Channel interrupt, also the channel's global status bit |
| cb_addr_o | output | 32 | Current control-block address |

## Verification
The hardest case to reach is a control/status write that lands in the same clock cycle as an engine completion. In that cycle the priorities of set, clear and reset all meet: the END, INT and paused flags, ACTIVE and the control-block address each resolve differently. Directed steps drive the write and the `eng_done` pulse in the same cycle. The random phase picks that pairing on purpose, with random clear and reset bits. A bench reference model predicts the result of every step, and every register is read back after each step.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
    localparam int DATA_W   = 32;
    localparam int OFS_W    = 8;
    localparam int N_DESC   = 6;

    // word indices inside the channel window (byte offset >> 2)
    localparam int IDX_CS   = 0;
    localparam int IDX_CB   = 1;
    localparam int IDX_DESC = 2;
    localparam int IDX_DBG  = IDX_DESC + N_DESC;

    // control/status bit positions
    localparam int B_ACT    = 0;
    localparam int B_END    = 1;
    localparam int B_INT    = 2;
    localparam int B_PAUSE  = 4;
    localparam int B_HELD   = 5;
    localparam int B_ERR    = 8;
    localparam int B_ABORT  = 30;
    localparam int B_SRST   = 31;

    localparam logic [31:0] CS_WR_MASK  = 32'h30FF_0001;
    localparam logic [31:0] FIELD_MASK  = CS_WR_MASK & ~(32'h1 << B_ACT);

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/dcsr_chan_fsm.sv
module dcsr_chan_fsm
    import dcsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_cs,
    input  logic wr_active,
    input  logic eng_done,
    output logic active,
    output logic start_evt,
    output logic start_o
);
    ch_state_e state_q, state_d;

    // transitions: go, halt, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (wr_cs && wr_active && !eng_done) state_d = CH_RUN;
            CH_RUN: begin
                if (eng_done)                     state_d = CH_IDLE;
                else if (wr_cs && !wr_active)     state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    assign active    = (state_q == CH_RUN);
    assign start_evt = (state_q == CH_IDLE) && (state_d == CH_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_o <= 1'b0;
        else        start_o <= start_evt;
    end

    assert_start_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (active && !$past(active)));
    assert_done_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !active);
    assert_no_start_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !start_o);
endmodule

// File: rtl/dcsr_status.sv
module dcsr_status
    import dcsr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cs,
    input  logic          wr_cb,
    input  logic [DW-1:0] wdata,
    input  logic          active,
    input  logic          start_evt,
    input  logic          eng_done,
    input  logic          eng_int_req,
    input  logic          eng_err,
    input  logic          eng_held,
    input  logic [DW-1:0] eng_next_addr,
    output logic [DW-1:0] cs_word,
    output logic [DW-1:0] cb_addr,
    output logic          irq
);
    logic          end_q, int_q, pause_q, err_q;
    logic [DW-1:0] field_q;
    logic          srst;

    assign srst = wr_cs && wdata[B_SRST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_q   <= 1'b0;
            int_q   <= 1'b0;
            pause_q <= 1'b0;
            err_q   <= 1'b0;
            field_q <= '0;
        end else if (srst) begin
            end_q   <= 1'b0;
            int_q   <= 1'b0;
            pause_q <= 1'b0;
            err_q   <= 1'b0;
            field_q <= wdata & FIELD_MASK[DW-1:0];
        end else begin
            if (wr_cs && wdata[B_END])      end_q <= 1'b0;
            else if (eng_done)              end_q <= 1'b1;
            if (wr_cs && wdata[B_INT])      int_q <= 1'b0;
            else if (eng_done && eng_int_req) int_q <= 1'b1;
            if (start_evt)                  pause_q <= 1'b0;
            else if (eng_done)              pause_q <= 1'b1;
            if (eng_err)                    err_q <= 1'b1;
            if (wr_cs)                      field_q <= wdata & FIELD_MASK[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cb_addr <= '0;
        else if (srst)     cb_addr <= '0;
        else if (wr_cb)    cb_addr <= wdata;
        else if (eng_done) cb_addr <= eng_next_addr;
    end

    always_comb begin
        cs_word          = field_q;
        cs_word[B_ACT]   = active;
        cs_word[B_END]   = end_q;
        cs_word[B_INT]   = int_q;
        cs_word[B_PAUSE] = pause_q;
        cs_word[B_HELD]  = eng_held;
        cs_word[B_ERR]   = err_q;
    end

    assign irq = int_q;

    assert_int_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cs && wdata[B_INT]) |=> !irq);
    assert_end_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cs && wdata[B_END]) |=> !cs_word[B_END]);
    assert_done_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !(wr_cs && (wdata[B_END] || wdata[B_SRST]))) |=> cs_word[B_END]);
    assert_srst_cb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (cb_addr == '0 && !cs_word[B_ERR]));
    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_word[B_ERR] && !srst) |=> cs_word[B_ERR]);
endmodule

// File: rtl/dcsr_desc_mirror.sv
module dcsr_desc_mirror
    import dcsr_pkg::*;
#(
    parameter int N  = N_DESC,
    parameter int DW = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [N-1:0][DW-1:0] din,
    output logic [N-1:0][DW-1:0] dout
);
    for (genvar g = 0; g < N; g++) begin : g_fld
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    dout[g] <= '0;
            else if (load) dout[g] <= din[g];
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dcsr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          eng_done,
    input  logic          eng_int_req,
    input  logic          eng_err,
    input  logic          eng_held,
    input  logic [DW-1:0] eng_next_addr,
    input  logic          eng_desc_vld,
    input  logic [DW-1:0] eng_desc_info,
    input  logic [DW-1:0] eng_desc_src,
    input  logic [DW-1:0] eng_desc_dst,
    input  logic [DW-1:0] eng_desc_len,
    input  logic [DW-1:0] eng_desc_stride,
    input  logic [DW-1:0] eng_desc_next,
    output logic          start_o,
    output logic          irq_o,
    output logic [DW-1:0] cb_addr_o
);
    localparam int IW = AW - 2;

    logic          aligned;
    logic [IW-1:0] widx;
    logic          wr_cs, wr_cb, wr_dbg;
    logic          active, start_evt;
    logic [DW-1:0] cs_word, dbg_q;
    logic [N_DESC-1:0][DW-1:0] desc_in, desc_q;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign widx    = bus_addr[AW-1:2];
    assign wr_cs   = bus_wr && aligned && (widx == IW'(IDX_CS));
    assign wr_cb   = bus_wr && aligned && (widx == IW'(IDX_CB));
    assign wr_dbg  = bus_wr && aligned && (widx == IW'(IDX_DBG));

    dcsr_chan_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cs     (wr_cs),
        .wr_active (bus_wdata[B_ACT]),
        .eng_done  (eng_done),
        .active    (active),
        .start_evt (start_evt),
        .start_o   (start_o)
    );

    dcsr_status #(.DW(DW)) u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_cs         (wr_cs),
        .wr_cb         (wr_cb),
        .wdata         (bus_wdata),
        .active        (active),
        .start_evt     (start_evt),
        .eng_done      (eng_done),
        .eng_int_req   (eng_int_req),
        .eng_err       (eng_err),
        .eng_held      (eng_held),
        .eng_next_addr (eng_next_addr),
        .cs_word       (cs_word),
        .cb_addr       (cb_addr_o),
        .irq           (irq_o)
    );

    assign desc_in[0] = eng_desc_info;
    assign desc_in[1] = eng_desc_src;
    assign desc_in[2] = eng_desc_dst;
    assign desc_in[3] = eng_desc_len;
    assign desc_in[4] = eng_desc_stride;
    assign desc_in[5] = eng_desc_next;

    dcsr_desc_mirror #(.N(N_DESC), .DW(DW)) u_mirror (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (eng_desc_vld),
        .din   (desc_in),
        .dout  (desc_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dbg_q <= '0;
        else if (wr_dbg) dbg_q <= bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (widx == IW'(IDX_CS))       bus_rdata = cs_word;
            else if (widx == IW'(IDX_CB))  bus_rdata = cb_addr_o;
            else if (widx == IW'(IDX_DBG)) bus_rdata = dbg_q;
            else if (widx >= IW'(IDX_DESC) && widx < IW'(IDX_DBG))
                bus_rdata = desc_q[widx - IW'(IDX_DESC)];
        end
    end

    assert_dbg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dbg |=> $stable(dbg_q));
    assert_irq_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == cs_word[B_INT]);
endmodule

// File: tb/dma_chan_csr_tb_top.sv
`timescale 1ns/1ps
module dma_chan_csr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_done = 1'b0, eng_int_req = 1'b0, eng_err = 1'b0, eng_held = 1'b0;
    logic [31:0] eng_next_addr = '0;
    logic        eng_desc_vld = 1'b0;
    logic [31:0] d_info = '0, d_src = '0, d_dst = '0, d_len = '0, d_str = '0, d_nxt = '0;
    logic        start_o, irq_o;
    logic [31:0] cb_addr_o;

    always #4 clk = ~clk;

    dma_chan_csr dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .eng_int_req(eng_int_req), .eng_err(eng_err),
        .eng_held(eng_held), .eng_next_addr(eng_next_addr),
        .eng_desc_vld(eng_desc_vld), .eng_desc_info(d_info), .eng_desc_src(d_src),
        .eng_desc_dst(d_dst), .eng_desc_len(d_len), .eng_desc_stride(d_str),
        .eng_desc_next(d_nxt), .start_o(start_o), .irq_o(irq_o), .cb_addr_o(cb_addr_o)
    );

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    // reference model state
    bit          m_act, m_end, m_int, m_pause, m_err, m_start;
    logic [31:0] m_field, m_cb, m_dbg;
    logic [31:0] m_desc [6];

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_cs();
        logic [31:0] v;
        v = m_field;
        v[0] = m_act; v[1] = m_end; v[2] = m_int;
        v[4] = m_pause; v[5] = eng_held; v[8] = m_err;
        return v;
    endfunction

    task automatic model_reset();
        m_act = 0; m_end = 0; m_int = 0; m_pause = 0; m_err = 0; m_start = 0;
        m_field = '0; m_cb = '0; m_dbg = '0;
        for (int i = 0; i < 6; i++) m_desc[i] = '0;
    endtask

    task automatic model_step(bit wr, logic [7:0] a, logic [31:0] wd, bit dn,
                              bit ir, bit er, bit dv);
        bit wcs, srst, st;
        wcs  = wr && a == 8'h00;
        srst = wcs && wd[31];
        st   = wcs && wd[0] && !m_act && !dn;
        if (dn) begin m_end = 1; m_pause = 1; if (ir) m_int = 1; end
        if (er) m_err = 1;
        if (st) m_pause = 0;
        if (wcs && wd[1]) m_end = 0;
        if (wcs && wd[2]) m_int = 0;
        if (wcs) begin m_field = wd & 32'h30FF_0000; m_act = wd[0]; end
        if (dn) m_act = 0;
        if (dn) m_cb = eng_next_addr;
        if (wr && a == 8'h04) m_cb = wd;
        if (wr && a == 8'h20) m_dbg = wd;
        if (srst) begin m_end = 0; m_int = 0; m_pause = 0; m_err = 0; m_cb = '0; end
        if (dv) begin
            m_desc[0] = d_info; m_desc[1] = d_src; m_desc[2] = d_dst;
            m_desc[3] = d_len;  m_desc[4] = d_str; m_desc[5] = d_nxt;
        end
        m_start = st;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.4;
        v = bus_rdata;
    endtask

    task automatic check_all();
        logic [31:0] v;
        chk("R3 start_o", {31'b0, start_o}, {31'b0, m_start});
        chk("R5 irq_o", {31'b0, irq_o}, {31'b0, m_int});
        chk("R9 cb_addr_o", cb_addr_o, m_cb);
        rd(8'h00, v); chk("R2 cs", v, exp_cs());
        rd(8'h04, v); chk("R9 cb", v, m_cb);
        for (int i = 0; i < 6; i++) begin
            rd(8'(8 + 4 * i), v); chk("R10 desc", v, m_desc[i]);
        end
        rd(8'h20, v); chk("R9 dbg", v, m_dbg);
        rd(8'h24, v); chk("R11 undef", v, 32'h0);
        rd(8'h01, v); chk("R11 unaligned", v, 32'h0);
    endtask

    task automatic step(bit wr, logic [7:0] a, logic [31:0] wd, bit dn, bit ir,
                        bit er, bit dv, logic [31:0] nxt);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = wd;
        eng_done = dn; eng_int_req = ir; eng_err = er; eng_desc_vld = dv;
        eng_next_addr = nxt;
        model_step(wr, a, wd, dn, ir, er, dv);
        @(posedge clk);
        #1;
        bus_wr = 0; eng_done = 0; eng_err = 0; eng_desc_vld = 0;
        check_all();
    endtask

    initial begin : wdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(8'h00, v); chk("R1 cs reset", v, 32'h0);
        rd(8'h04, v); chk("R1 cb reset", v, 32'h0);
        rd(8'h20, v); chk("R1 dbg reset", v, 32'h0);
        chk("R1 irq reset", {31'b0, irq_o}, 32'h0);
        chk("R1 start reset", {31'b0, start_o}, 32'h0);
        // R2/R6 all bits written, active 0
        step(1, 8'h00, 32'hFFFF_FFFE, 0, 0, 0, 0, 0);
        rd(8'h00, v); chk("R2 masked readback", v, 32'h30FF_0000);
        // R9 control block and debug
        step(1, 8'h04, 32'h0000_1000, 0, 0, 0, 0, 0);
        step(1, 8'h20, 32'hCAFE_F00D, 0, 0, 0, 0, 0);
        step(1, 8'h0C, 32'h1234_5678, 0, 0, 0, 0, 0);
        rd(8'h0C, v); chk("R9 ro offset ignored", v, 32'h0);
        // R3 start on 0->1, none on 1->1
        step(1, 8'h00, 32'h0000_0001, 0, 0, 0, 0, 0);
        chk("R3 start pulse", {31'b0, start_o}, 32'h1);
        step(1, 8'h00, 32'h0000_0001, 0, 0, 0, 0, 0);
        chk("R3 no repeat start", {31'b0, start_o}, 32'h0);
        // R2 abort has no effect
        step(1, 8'h00, 32'h4000_0001, 0, 0, 0, 0, 0);
        rd(8'h00, v); chk("R2 abort ignored", v, 32'h0000_0001);
        // R7 completion with interrupt
        step(0, 8'h00, 0, 1, 1, 0, 0, 32'h0000_2000);
        rd(8'h00, v); chk("R7 completion flags", v, 32'h0000_0016);
        chk("R7 next cb", cb_addr_o, 32'h0000_2000);
        // R4 END clear, R5 INT clear
        step(1, 8'h00, 32'h0000_0002, 0, 0, 0, 0, 0);
        rd(8'h00, v); chk("R4 end cleared", v, 32'h0000_0014);
        step(1, 8'h00, 32'h0000_0004, 0, 0, 0, 0, 0);
        chk("R5 irq dropped", {31'b0, irq_o}, 32'h0);
        // R13 paused cleared on start
        step(1, 8'h00, 32'h0000_0001, 0, 0, 0, 0, 0);
        rd(8'h00, v); chk("R13 paused cleared", v, 32'h0000_0001);
        // R8 simultaneous write and completion
        step(1, 8'h00, 32'h0000_0007, 1, 1, 0, 0, 32'h0000_3000);
        rd(8'h00, v); chk("R8 write clear wins", v, 32'h0000_0010);
        chk("R8 no start", {31'b0, start_o}, 32'h0);
        // R12 error and held
        eng_held = 1;
        step(0, 8'h00, 0, 0, 0, 1, 0, 0);
        rd(8'h00, v); chk("R12 err and held", v, 32'h0000_0130);
        step(1, 8'h00, 32'h0000_0000, 0, 0, 0, 0, 0);
        rd(8'h00, v); chk("R12 err sticky", v[8] ? 32'h1 : 32'h0, 32'h1);
        eng_held = 0;
        // R6 soft reset
        step(1, 8'h00, 32'h8000_0000, 0, 0, 0, 0, 0);
        rd(8'h00, v); chk("R6 soft reset cs", v, 32'h0);
        chk("R6 soft reset cb", cb_addr_o, 32'h0);
        rd(8'h20, v); chk("R6 dbg kept", v, 32'hCAFE_F00D);
        // R10 descriptor capture
        d_info = 32'h11; d_src = 32'h22; d_dst = 32'h33; d_len = 32'h44;
        d_str = 32'h55; d_nxt = 32'h66;
        step(0, 8'h00, 0, 0, 0, 0, 1, 0);
        rd(8'h14, v); chk("R10 length field", v, 32'h44);
        // R11 undefined write
        step(1, 8'h24, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        step(1, 8'h22, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        // random phase
        for (int k = 0; k < 600; k++) begin
            int op;
            logic [31:0] wd;
            op = $urandom_range(0, 9);
            wd = $urandom;
            if ($urandom_range(0, 7) != 0) wd[31] = 1'b0;
            eng_held = $urandom_range(0, 1);
            d_info = $urandom; d_src = $urandom; d_dst = $urandom;
            d_len = $urandom; d_str = $urandom; d_nxt = $urandom;
            case (op)
                0, 1: step(1, 8'h00, wd, 0, 0, 0, 0, 0);
                2: step(1, 8'h04, wd, 0, 0, 0, 0, 0);
                3: step(1, 8'h20, wd, 0, 0, 0, 0, 0);
                4: step(1, 8'(4 * $urandom_range(2, 7)), wd, 0, 0, 0, 0, 0);
                5: step(1, 8'($urandom_range(33, 255)), wd, 0, 0, 0, 0, 0);
                6: step(0, 8'h00, 0, m_act, $urandom_range(0, 1), 0, 0, $urandom);
                7: step(0, 8'h00, 0, 0, 0, 0, 1, 0);
                8: step(0, 8'h00, 0, 0, 0, $urandom_range(0, 1), 0, 0);
                default: step(1, 8'h00, wd, 1, $urandom_range(0, 1), 0, 0, $urandom);
            endcase
        end
        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule